// File: doc/BRIEF.md
# Clock Synthesizer Configuration Port

This block holds the programming word of a frequency synthesizer: a 3-bit test-select field, a 2-bit output-divider code and a 9-bit loop-divider modulus. Two paths can write these holding registers. A parallel path copies the divider values from input pins and forces the test field to zero. A serial path collects a 14-bit frame in a shift register and, on a load strobe, copies the whole frame into the holding registers. The usual flow is a parallel load at power-on and, later and only if needed, serial reprogramming. The test field can be written only through the serial path.

Everything runs on the rising edge of the serial clock. The shift register takes one bit on every edge, whatever the load inputs do. A small load controller decides at each edge which source, if any, writes the holding registers. It has three named states: PRESET (parallel load active), COMMIT (serial frame transferred) and IDLE (holding registers keep their value). The transitions are named by their cause. Parallel-request enters PRESET from any state whenever the active-low parallel load is low. Serial-request enters COMMIT from any state when the serial strobe is high and the parallel load is inactive. Release enters IDLE when neither request is present. The state register records the action taken at the last edge.

A test output shows the oldest bit of the shift register while the test field is zero. Two other test codes drive constant levels.

Top module: `synth_cfg_port`

## Requirements
- R1: An active-low asynchronous reset clears the shift register and the T, N and M holding registers at once, so that `t_q`, `n_q`, `m_q`, `sdo` and `test_o` all read 0 without a clock edge.
- R2: On every rising edge of `sclk` the shift register moves up one place and takes `sdata` into bit 0. This also happens on edges where a load occurs. `sdo` is bit 13, the bit sampled 14 edges earlier.
- R3: Frame layout: the first of 14 bits lands in `t_q[2]`, then `t_q[1]`, `t_q[0]`, `n_q[1]`, `n_q[0]`, `m_q[8]` and on down to `m_q[0]` as the last bit. Each field arrives most-significant bit first, so shift bits [13:11] form T, [10:9] form N and [8:0] form M.
- R4: At an edge where `ser_ld` is 1 and `par_ld_n` is 1, T, N and M take the shift register contents as they were before that edge's shift.
- R5: At an edge where `par_ld_n` is 0, `m_q` takes `p_m`, `n_q` takes `p_n` and `t_q` becomes 000.
- R6: When `par_ld_n` is 0 and `ser_ld` is 1 at the same edge, the parallel load wins and the shift register contents are not transferred.
- R7: At an edge where `par_ld_n` is 1 and `ser_ld` is 0, T, N and M keep their values whatever `sdata` carries.
- R8: `test_o` equals `sdo` when `t_q` = 000, is 1 when `t_q` = 001 and is 0 for every other code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdata | input | 1 | Serial frame data |
| ser_ld | input | 1 | Serial load strobe, active high |
| par_ld_n | input | 1 | Parallel load, active low |
| p_m | input | 9 | Parallel loop-divider modulus |
| p_n | input | 2 | Parallel output-divider code |
| t_q | output | 3 | Registered test-select field |
| n_q | output | 2 | Registered output-divider code |
| m_q | output | 9 | Registered loop-divider modulus |
| sdo | output | 1 | Oldest bit of the shift register |
| test_o | output | 1 | Test pin, selected by `t_q` |

## Verification
Two pairs of functions can fall in the same edge. The first pair is the parallel and serial loads. The bench fills a frame whose test field is nonzero, then raises `ser_ld` while `par_ld_n` is low. It counts the edge correct only if the pin values and a zero test field appear. The second pair is a serial transfer and a shift, which happen on every commit edge. That is judged by checking that the holding registers take the frame from before the shift while `sdo` keeps following a bench model of the shift register across the edge.

// File: rtl/scp_pkg.sv
package scp_pkg;

    // Action taken by the load controller at the last clock edge.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRESET = 2'd1,
        ST_COMMIT = 2'd2
    } ld_state_e;

endpackage

// File: rtl/scp_shifter.sv
module scp_shifter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         din,
    output logic [W-1:0] q
);

    logic [W:0] chain;

    assign chain[0] = din;

    for (genvar i = 0; i < W; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else begin
                q[i] <= chain[i];
            end
        end
        assign chain[i+1] = q[i];
    end

endmodule

// File: rtl/scp_load_ctl.sv
module scp_load_ctl
    import scp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      par_ld_n,
    input  logic      ser_ld,
    output ld_state_e state_q,
    output logic      do_par,
    output logic      do_ser
);

    ld_state_e nxt;

    // State register: records the action taken at the last edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= nxt;
        end
    end

    // Transition choice: parallel request, serial request or release.
    always_comb begin
        unique casez ({~par_ld_n, ser_ld})
            2'b1?:   nxt = ST_PRESET;
            2'b01:   nxt = ST_COMMIT;
            2'b00:   nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Output decode: load strobes for the edge ahead.
    always_comb begin
        do_par = 1'b0;
        do_ser = 1'b0;
        unique case (nxt)
            ST_PRESET: do_par = 1'b1;
            ST_COMMIT: do_ser = 1'b1;
            ST_IDLE:   ;
            default:   ;
        endcase
    end

endmodule

// File: rtl/scp_hold_regs.sv
module scp_hold_regs #(
    parameter int T_W = 3,
    parameter int N_W = 2,
    parameter int M_W = 9,
    localparam int F_W = T_W + N_W + M_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           do_par,
    input  logic           do_ser,
    input  logic [M_W-1:0] p_m,
    input  logic [N_W-1:0] p_n,
    input  logic [F_W-1:0] frame,
    output logic [T_W-1:0] t_q,
    output logic [N_W-1:0] n_q,
    output logic [M_W-1:0] m_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
            n_q <= '0;
            m_q <= '0;
        end else if (do_par) begin
            t_q <= '0;
            n_q <= p_n;
            m_q <= p_m;
        end else if (do_ser) begin
            t_q <= frame[F_W-1 -: T_W];
            n_q <= frame[M_W +: N_W];
            m_q <= frame[M_W-1:0];
        end
    end

endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
    import scp_pkg::*;
#(
    parameter int T_W = 3,
    parameter int N_W = 2,
    parameter int M_W = 9,
    localparam int F_W = T_W + N_W + M_W
) (
    input  logic           sclk,
    input  logic           rst_n,
    input  logic           sdata,
    input  logic           ser_ld,
    input  logic           par_ld_n,
    input  logic [M_W-1:0] p_m,
    input  logic [N_W-1:0] p_n,
    output logic [T_W-1:0] t_q,
    output logic [N_W-1:0] n_q,
    output logic [M_W-1:0] m_q,
    output logic           sdo,
    output logic           test_o
);

    logic [F_W-1:0] sh_w;
    ld_state_e      state_q;
    logic           do_par;
    logic           do_ser;

    scp_shifter #(.W(F_W)) u_shift (
        .clk   (sclk),
        .rst_n (rst_n),
        .din   (sdata),
        .q     (sh_w)
    );

    scp_load_ctl u_ctl (
        .clk      (sclk),
        .rst_n    (rst_n),
        .par_ld_n (par_ld_n),
        .ser_ld   (ser_ld),
        .state_q  (state_q),
        .do_par   (do_par),
        .do_ser   (do_ser)
    );

    scp_hold_regs #(.T_W(T_W), .N_W(N_W), .M_W(M_W)) u_hold (
        .clk    (sclk),
        .rst_n  (rst_n),
        .do_par (do_par),
        .do_ser (do_ser),
        .p_m    (p_m),
        .p_n    (p_n),
        .frame  (sh_w),
        .t_q    (t_q),
        .n_q    (n_q),
        .m_q    (m_q)
    );

    assign sdo = sh_w[F_W-1];

    always_comb begin
        if (t_q == '0) begin
            test_o = sdo;
        end else if (t_q == T_W'(1)) begin
            test_o = 1'b1;
        end else begin
            test_o = 1'b0;
        end
    end

endmodule

// File: rtl/synth_cfg_port_chk.sv
module synth_cfg_port_chk
    import scp_pkg::*;
#(
    parameter int T_W = 3,
    parameter int N_W = 2,
    parameter int M_W = 9,
    localparam int F_W = T_W + N_W + M_W
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sdata,
    input logic           ser_ld,
    input logic           par_ld_n,
    input logic [M_W-1:0] p_m,
    input logic [N_W-1:0] p_n,
    input logic [T_W-1:0] t_q,
    input logic [N_W-1:0] n_q,
    input logic [M_W-1:0] m_q,
    input logic           sdo,
    input logic           test_o,
    input logic [F_W-1:0] sh,
    input ld_state_e      state_q
);

    // R2
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sh[0] == $past(sdata)) && (sh[F_W-1:1] == $past(sh[F_W-2:0])));

    // R4
    ser_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_ld_n && ser_ld) |=> ({t_q, n_q, m_q} == $past(sh)));

    // R5
    par_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_ld_n) |=> (t_q == '0) && (n_q == $past(p_n)) && (m_q == $past(p_m)));

    // R6
    par_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_ld_n && ser_ld) |=> (state_q == ST_PRESET) && (m_q == $past(p_m)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_ld_n && !ser_ld) |=> $stable(t_q) && $stable(n_q) && $stable(m_q));

    // R8
    test_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q == '0) |-> (test_o == sdo));

endmodule

bind synth_cfg_port synth_cfg_port_chk #(.T_W(T_W), .N_W(N_W), .M_W(M_W)) u_chk (
    .clk      (sclk),
    .rst_n    (rst_n),
    .sdata    (sdata),
    .ser_ld   (ser_ld),
    .par_ld_n (par_ld_n),
    .p_m      (p_m),
    .p_n      (p_n),
    .t_q      (t_q),
    .n_q      (n_q),
    .m_q      (m_q),
    .sdo      (sdo),
    .test_o   (test_o),
    .sh       (sh_w),
    .state_q  (state_q)
);

// File: tb/synth_cfg_port_bench.sv
module synth_cfg_port_bench;

    logic       sclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sdata = 1'b0;
    logic       ser_ld = 1'b0;
    logic       par_ld_n = 1'b1;
    logic [8:0] p_m = '0;
    logic [1:0] p_n = '0;
    logic [2:0] t_q;
    logic [1:0] n_q;
    logic [8:0] m_q;
    logic       sdo;
    logic       test_o;

    int total = 0;
    int bad = 0;

    logic [13:0] exp_sh = '0;
    logic [2:0]  exp_t = '0;
    logic [1:0]  exp_n = '0;
    logic [8:0]  exp_m = '0;

    always #5 sclk = ~sclk;

    synth_cfg_port u_synth_cfg_port (
        .sclk     (sclk),
        .rst_n    (rst_n),
        .sdata    (sdata),
        .ser_ld   (ser_ld),
        .par_ld_n (par_ld_n),
        .p_m      (p_m),
        .p_n      (p_n),
        .t_q      (t_q),
        .n_q      (n_q),
        .m_q      (m_q),
        .sdo      (sdo),
        .test_o   (test_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // One rising edge; the bench model shifts alongside (R2).
    task automatic tick();
        exp_sh = {exp_sh[12:0], sdata};
        @(posedge sclk);
        @(negedge sclk);
    endtask

    function automatic logic exp_test(input logic [2:0] t, input logic [13:0] s);
        if (t == 3'd0) return s[13];
        if (t == 3'd1) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check_regs(input string req);
        check(req, {13'd0, t_q}, {13'd0, exp_t});
        check(req, {14'd0, n_q}, {14'd0, exp_n});
        check(req, {7'd0, m_q}, {7'd0, exp_m});
    endtask

    task automatic shift_frame(input logic [13:0] f);
        for (int i = 13; i >= 0; i--) begin
            sdata = f[i];
            tick();
            check("R2 sdo", {15'd0, sdo}, {15'd0, exp_sh[13]});
            check_regs("R7 hold while shifting");
        end
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        #3;
        check("R1 t", {13'd0, t_q}, 16'd0);
        check("R1 n", {14'd0, n_q}, 16'd0);
        check("R1 m", {7'd0, m_q}, 16'd0);
        check("R1 sdo", {15'd0, sdo}, 16'd0);
        check("R1 test", {15'd0, test_o}, 16'd0);
        @(negedge sclk);
        rst_n = 1'b1;

        // R5: parallel sweep over every modulus, all divider codes
        for (int m = 0; m < 512; m++) begin
            par_ld_n = 1'b0;
            p_m = 9'(m);
            p_n = 2'((m * 3 + (m >> 4)) % 4);
            sdata = ((m * 7) % 5) > 1;
            tick();
            exp_t = 3'd0; exp_n = p_n; exp_m = p_m;
            check_regs("R5 parallel");
            check("R8 test follows sdo", {15'd0, test_o}, {15'd0, exp_sh[13]});
        end
        par_ld_n = 1'b1;

        // R2 R3 R4 R8: serial frames covering every test code
        for (int k = 0; k < 128; k++) begin
            logic [13:0] f;
            f[13:11] = 3'(k % 8);
            f[10:9]  = 2'((k / 8) % 4);
            f[8:0]   = 9'((k * 37 + k * k * 5 + 3) % 512);
            shift_frame(f);
            sdata = k[0];
            ser_ld = 1'b1;
            tick();
            ser_ld = 1'b0;
            exp_t = f[13:11]; exp_n = f[10:9]; exp_m = f[8:0];
            check_regs("R3 R4 serial transfer");
            check("R2 sdo after commit", {15'd0, sdo}, {15'd0, exp_sh[13]});
            check("R8 test pin", {15'd0, test_o}, {15'd0, exp_test(exp_t, exp_sh)});
        end

        // R6: both loads at one edge, parallel wins
        shift_frame(14'b101_11_110011001);
        ser_ld = 1'b1;
        par_ld_n = 1'b0;
        p_m = 9'h1A5;
        p_n = 2'd2;
        tick();
        ser_ld = 1'b0;
        par_ld_n = 1'b1;
        exp_t = 3'd0; exp_n = 2'd2; exp_m = 9'h1A5;
        check_regs("R6 parallel priority");

        // R7: long idle run with toggling data
        for (int j = 0; j < 40; j++) begin
            sdata = ((j * 11) % 3) == 0;
            tick();
            check_regs("R7 hold");
            check("R8 test when T=0", {15'd0, test_o}, {15'd0, exp_sh[13]});
        end

        // R1: asynchronous reset between edges
        #2;
        rst_n = 1'b0;
        #1;
        check("R1 async t", {13'd0, t_q}, 16'd0);
        check("R1 async m", {7'd0, m_q}, 16'd0);
        check("R1 async n", {14'd0, n_q}, 16'd0);
        check("R1 async sdo", {15'd0, sdo}, 16'd0);
        @(negedge sclk);
        rst_n = 1'b1;
        exp_sh = '0; exp_t = '0; exp_n = '0; exp_m = '0;
        sdata = 1'b1;
        tick();
        check("R2 after reset", {15'd0, sdo}, 16'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule